// File: doc/BRIEF.md
# Microcoded Restoring Fraction Divider

This block divides one unsigned binary fraction by another under the control of a small microprogram. A `start` pulse, taken while the block is idle, captures the dividend and the divisor into the register block. A micro-sequencer then steps through microwords held in a compact ROM. Every arithmetic step runs through one shared ALU: the operand checks, the trial subtraction, the restoring addition, the two shifts and the iteration count. The ALU's carry and zero flags return to the sequencer and decide the next micro-address.

The quotient has one integer bit followed by DW-1 fraction bits, so equal operands yield exactly 1.0. A division whose dividend exceeds its divisor, or whose divisor is zero, stops early with the overflow flag raised.

The number of micro-cycles depends on the data, because a restoring step costs one extra cycle for each zero quotient bit. For self-test, each micro-cycle's ALU stimulus and response appear at the ports with a valid strobe, so a signature monitor can compress them.

Top module: `fdiv_ucode`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `busy`, `done`, `alu_valid`, `ovf` and `quotient` are all 0.
- R2: For 0 < divisor and dividend <= divisor, the final quotient equals floor(dividend * 2^(DW-1) / divisor). Bit DW-1 of the quotient is the integer bit.
- R3: When dividend equals divisor and the divisor is nonzero, the quotient is exactly 1.0, that is 2^(DW-1).
- R4: A zero divisor, or a dividend greater than the divisor, ends the division with `ovf` = 1 and `quotient` = 0. A zero divisor is detected after one ALU operation. A dividend greater than a nonzero divisor is detected after two ALU operations.
- R5: A division that does not overflow issues exactly 3 + 4*DW + Z ALU operations, where Z is the number of zero bits in the DW-bit quotient.
- R6: `done` is a one-cycle pulse. `busy` is low on the cycle `done` is high and on the cycle after it.
- R7: A `start` that arrives while `busy` is high is ignored. The running division completes with the operands it captured.
- R8: `alu_valid` is high only while `busy` is high. `alu_out` is {carry, zero, result[DW:0]}. The first ALU operation of every division passes the divisor through, so its result equals the divisor and its zero flag equals (divisor == 0).
- R9: After `done`, `quotient` and `ovf` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; honoured only while idle |
| dividend | input | DW | Unsigned fraction numerator |
| divisor | input | DW | Unsigned fraction denominator |
| quotient | output | DW | Result, one integer bit and DW-1 fraction bits |
| ovf | output | 1 | Overflow or zero divisor for the last division |
| busy | output | 1 | Microprogram running |
| done | output | 1 | One-cycle pulse when the result is final |
| alu_valid | output | 1 | ALU operation in this cycle |
| alu_in | output | 2*DW+5 | {opcode[1:0], carry-in, operand A[DW:0], operand B[DW:0]}; opcode 0 pass, 1 add, 2 subtract, 3 shift left |
| alu_out | output | DW+3 | {carry or borrow, zero, result[DW:0]} |

## Verification
The assertions assume that reset is applied before the first meaningful clock and that `start` is a clean level sampled on the rising edge. They place no constraint on operand values, because the operands are captured only on an accepted `start`.

The bench changes `start` and the operands only at falling edges. It sweeps every operand pair of a six-bit configuration, which covers the in-range, equal-operand, zero-divisor and overflow classes. A separate sequence raises `start` in the middle of a division and then holds the block idle to observe that the result stays put.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  localparam int UPC_W = 4;

  typedef enum logic [1:0] {OP_PASS = 2'd0, OP_ADD = 2'd1, OP_SUB = 2'd2, OP_SHL = 2'd3} alu_op_e;
  typedef enum logic [2:0] {SA_REM, SA_DVD, SA_DVS, SA_QUO, SA_CNT} asel_e;
  typedef enum logic [1:0] {SB_DVS, SB_DVD, SB_ONE, SB_ZERO} bsel_e;
  typedef enum logic [1:0] {WD_NONE, WD_REM, WD_QUO, WD_CNT} dest_e;
  typedef enum logic [1:0] {BR_NEXT, BR_JZ, BR_JC, BR_JNC} br_e;

  typedef struct packed {
    logic             use_alu;
    alu_op_e          op;
    asel_e            asel;
    bsel_e            bsel;
    dest_e            dest;
    logic             cin_q;
    logic             grab_q;
    logic             init;
    br_e              br;
    logic [UPC_W-1:0] target;
    logic             fin;
    logic             set_ovf;
  } uword_t;

  // Microprogram: restoring shift-subtract division with operand checks.
  function automatic uword_t urom(input logic [UPC_W-1:0] upc);
    uword_t w;
    w = '0;
    case (upc)
      4'd0: begin // divisor zero test
        w.use_alu = 1'b1; w.op = OP_PASS; w.asel = SA_DVS; w.bsel = SB_ZERO;
        w.br = BR_JZ; w.target = 4'd9;
      end
      4'd1: begin // divisor - dividend, borrow means overflow
        w.use_alu = 1'b1; w.op = OP_SUB; w.asel = SA_DVS; w.bsel = SB_DVD;
        w.br = BR_JC; w.target = 4'd9;
      end
      4'd2: begin // remainder <- dividend, preset counter
        w.use_alu = 1'b1; w.op = OP_PASS; w.asel = SA_DVD; w.bsel = SB_ZERO;
        w.dest = WD_REM; w.init = 1'b1;
      end
      4'd3: begin // trial subtraction
        w.use_alu = 1'b1; w.op = OP_SUB; w.asel = SA_REM; w.bsel = SB_DVS;
        w.dest = WD_REM; w.grab_q = 1'b1; w.br = BR_JNC; w.target = 4'd5;
      end
      4'd4: begin // restore
        w.use_alu = 1'b1; w.op = OP_ADD; w.asel = SA_REM; w.bsel = SB_DVS;
        w.dest = WD_REM;
      end
      4'd5: begin // shift quotient bit in
        w.use_alu = 1'b1; w.op = OP_SHL; w.asel = SA_QUO; w.bsel = SB_ZERO;
        w.dest = WD_QUO; w.cin_q = 1'b1;
      end
      4'd6: begin // shift remainder
        w.use_alu = 1'b1; w.op = OP_SHL; w.asel = SA_REM; w.bsel = SB_ZERO;
        w.dest = WD_REM;
      end
      4'd7: begin // count down, loop until borrow
        w.use_alu = 1'b1; w.op = OP_SUB; w.asel = SA_CNT; w.bsel = SB_ONE;
        w.dest = WD_CNT; w.br = BR_JNC; w.target = 4'd3;
      end
      4'd8: w.fin = 1'b1;
      4'd9: begin w.fin = 1'b1; w.set_ovf = 1'b1; end
      default: w.fin = 1'b1;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/fdiv_alu.sv
module fdiv_alu
  import fdiv_pkg::*;
#(
  parameter int W = 33
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         carry,
  output logic         zero
);

  // Returns {carry_or_borrow, result}.
  function automatic logic [W:0] eval(input alu_op_e f, input logic [W-1:0] x,
                                      input logic [W-1:0] z, input logic ci);
    logic [W:0] r;
    case (f)
      OP_ADD:  r = {1'b0, x} + {1'b0, z};
      OP_SUB:  r = {1'b0, x} - {1'b0, z};
      OP_SHL:  r = {x, ci};
      default: r = {1'b0, x};
    endcase
    return r;
  endfunction

  logic [W:0] res;

  always_comb begin
    res   = eval(op, a, b, cin);
    y     = res[W-1:0];
    carry = res[W];
    zero  = (res[W-1:0] == '0);
  end

endmodule

// File: rtl/fdiv_seq.sv
module fdiv_seq
  import fdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   carry,
  input  logic   zero,
  output uword_t uw,
  output logic   busy,
  output logic   accept,
  output logic   step,
  output logic   alu_valid,
  output logic   done
);

  logic [UPC_W-1:0] upc, upc_nxt;
  logic             take;

  always_comb begin
    uw     = urom(upc);
    accept = start && !busy;
    step   = busy;
    alu_valid = busy && uw.use_alu;
    case (uw.br)
      BR_JZ:   take = zero;
      BR_JC:   take = carry;
      BR_JNC:  take = !carry;
      default: take = 1'b0;
    endcase
    upc_nxt = take ? uw.target : upc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= busy && uw.fin;
      if (accept) begin
        busy <= 1'b1;
        upc  <= '0;
      end else if (busy) begin
        if (uw.fin) begin
          busy <= 1'b0;
          upc  <= '0;
        end else begin
          upc <= upc_nxt;
        end
      end
    end
  end

endmodule

// File: rtl/fdiv_regfile.sv
module fdiv_regfile
  import fdiv_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 5,
  parameter int W  = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          act,
  input  asel_e         asel,
  input  bsel_e         bsel,
  input  dest_e         dest,
  input  logic          cin_q,
  input  logic          grab_q,
  input  logic          init,
  input  logic          set_ovf,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  input  logic [W-1:0]  y,
  input  logic          carry,
  output logic [W-1:0]  a_bus,
  output logic [W-1:0]  b_bus,
  output logic          cin,
  output logic [DW-1:0] quotient,
  output logic          ovf
);

  logic [DW-1:0] dvd, dvs, quo;
  logic [W-1:0]  rem;
  logic [CW-1:0] cnt;
  logic          qbit;

  always_comb begin
    case (asel)
      SA_REM:  a_bus = rem;
      SA_DVD:  a_bus = {1'b0, dvd};
      SA_DVS:  a_bus = {1'b0, dvs};
      SA_QUO:  a_bus = {1'b0, quo};
      default: a_bus = {{(W-CW){1'b0}}, cnt};
    endcase
    case (bsel)
      SB_DVS:  b_bus = {1'b0, dvs};
      SB_DVD:  b_bus = {1'b0, dvd};
      SB_ONE:  b_bus = W'(1);
      default: b_bus = '0;
    endcase
    cin      = cin_q && qbit;
    quotient = quo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd  <= '0;
      dvs  <= '0;
      quo  <= '0;
      rem  <= '0;
      cnt  <= '0;
      qbit <= 1'b0;
      ovf  <= 1'b0;
    end else if (accept) begin
      dvd  <= dividend;
      dvs  <= divisor;
      quo  <= '0;
      qbit <= 1'b0;
      ovf  <= 1'b0;
    end else if (act) begin
      case (dest)
        WD_REM:  rem <= y;
        WD_QUO:  quo <= y[DW-1:0];
        WD_CNT:  cnt <= y[CW-1:0];
        default: ;
      endcase
      if (init)    cnt  <= CW'(DW - 1);
      if (grab_q)  qbit <= ~carry;
      if (set_ovf) ovf  <= 1'b1;
    end
  end

endmodule

// File: rtl/fdiv_ucode.sv
module fdiv_ucode
  import fdiv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   dividend,
  input  logic [DW-1:0]   divisor,
  output logic [DW-1:0]   quotient,
  output logic            ovf,
  output logic            busy,
  output logic            done,
  output logic            alu_valid,
  output logic [2*DW+4:0] alu_in,
  output logic [DW+2:0]   alu_out
);

  localparam int W  = DW + 1;
  localparam int CW = $clog2(DW);

  uword_t       uw;
  logic         accept, step;
  logic         carry, zero, cin;
  logic [W-1:0] a_bus, b_bus, y;

  fdiv_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .carry     (carry),
    .zero      (zero),
    .uw        (uw),
    .busy      (busy),
    .accept    (accept),
    .step      (step),
    .alu_valid (alu_valid),
    .done      (done)
  );

  fdiv_regfile #(.DW(DW), .CW(CW), .W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .act      (step),
    .asel     (uw.asel),
    .bsel     (uw.bsel),
    .dest     (uw.dest),
    .cin_q    (uw.cin_q),
    .grab_q   (uw.grab_q),
    .init     (uw.init),
    .set_ovf  (uw.set_ovf),
    .dividend (dividend),
    .divisor  (divisor),
    .y        (y),
    .carry    (carry),
    .a_bus    (a_bus),
    .b_bus    (b_bus),
    .cin      (cin),
    .quotient (quotient),
    .ovf      (ovf)
  );

  fdiv_alu #(.W(W)) u_alu (
    .op    (uw.op),
    .a     (a_bus),
    .b     (b_bus),
    .cin   (cin),
    .y     (y),
    .carry (carry),
    .zero  (zero)
  );

  assign alu_in  = {uw.op, cin, a_bus, b_bus};
  assign alu_out = {carry, zero, y};

endmodule

// File: rtl/fdiv_ucode_chk.sv
module fdiv_ucode_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          ovf,
  input logic          alu_valid,
  input logic [DW-1:0] quotient
);

  p_valid_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alu_valid |-> busy);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_ovf_zero_q_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> (quotient == '0));

  p_q_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovf) |-> (quotient <= {1'b1, {(DW-1){1'b0}}}));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(ovf)));

endmodule

bind fdiv_ucode fdiv_ucode_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .ovf       (ovf),
  .alu_valid (alu_valid),
  .quotient  (quotient)
);

// File: tb/fdiv_ucode_tb.sv
module fdiv_ucode_tb;

  localparam int DW = 6;
  localparam int W  = DW + 1;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [DW-1:0]   dividend = '0;
  logic [DW-1:0]   divisor = '0;
  logic [DW-1:0]   quotient;
  logic            ovf, busy, done, alu_valid;
  logic [2*DW+4:0] alu_in;
  logic [DW+2:0]   alu_out;

  int n_chk = 0;
  int n_bad = 0;

  fdiv_ucode #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .ovf(ovf), .busy(busy), .done(done),
    .alu_valid(alu_valid), .alu_in(alu_in), .alu_out(alu_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_div(input int a, input int b);
    int ops, cyc;
    logic [DW+2:0] first;
    bit got;
    longint q_exp;
    int ops_exp;
    bit ovf_exp;
    @(negedge clk);
    dividend = a[DW-1:0];
    divisor  = b[DW-1:0];
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ops = 0; cyc = 0; got = 0; first = '0;
    while (!done && cyc < 400) begin
      if (alu_valid) begin
        if (!got) first = alu_out;
        got = 1;
        ops++;
      end
      cyc++;
      @(negedge clk);
    end
    check(done == 1'b1, "R6 done seen", done, 1);
    ovf_exp = (b == 0) || (a > b);
    q_exp   = ovf_exp ? 0 : ((longint'(a) << (DW-1)) / b);
    if (b == 0)       ops_exp = 1;
    else if (a > b)   ops_exp = 2;
    else              ops_exp = 3 + 4*DW + (DW - $countones(q_exp[DW-1:0]));
    check(ovf == ovf_exp, "R4 ovf", ovf, ovf_exp);
    if (ovf_exp)            check(quotient == 0, "R4 quotient", quotient, 0);
    else if (a == b)        check(quotient == q_exp, "R3 unity", quotient, q_exp);
    else                    check(quotient == q_exp, "R2 quotient", quotient, q_exp);
    if (ovf_exp) check(ops == ops_exp, "R4 op count", ops, ops_exp);
    else         check(ops == ops_exp, "R5 op count", ops, ops_exp);
    check(first[W-1:0] == W'(b), "R8 first result", first[W-1:0], b);
    check(first[W] == (b == 0), "R8 first zero flag", first[W], (b == 0));
    @(negedge clk);
    check(!done && !busy, "R6 pulse ends", {done, busy}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check({busy, done, alu_valid, ovf} == 0 && quotient == 0, "R1 in reset",
          {busy, done, alu_valid, ovf, quotient}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, alu_valid, ovf} == 0 && quotient == 0, "R1 after reset",
          {busy, done, alu_valid, ovf, quotient}, 0);

    // Full operand sweep: R2, R3, R4, R5, R8
    for (int a = 0; a < (1 << DW); a++)
      for (int b = 0; b < (1 << DW); b++)
        run_div(a, b);

    // R7: start during a running division is ignored
    @(negedge clk);
    dividend = 6'd10; divisor = 6'd40; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    dividend = 6'd40; divisor = 6'd10; start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 400 && !done; i++) @(negedge clk);
    check(done && quotient == 8 && !ovf, "R7 ignored start", quotient, 8);

    // R9: result holds while idle
    for (int i = 0; i < 6; i++) begin
      dividend = DW'(i * 7);
      divisor  = DW'(i * 3);
      @(negedge clk);
    end
    check(quotient == 8 && !ovf && !busy, "R9 hold", quotient, 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule